// File: doc/BRIEF.md
# Configuration Request Routing Unit

This block sits on the root-complex side of a serial link controller. It turns one local configuration access into one of three outcomes: a Type 0 configuration request on the link, a Type 1 configuration request on the link, or a completion generated on the spot. An access carries a translated address, a read/write flag, a byte count, byte enables, write data and a source flag. The source flag tells whether the access came through an outbound translation window or through the indirect address/data register pair. The unit decodes the target bus, device, function and register fields from the address. It compares the bus against the primary, secondary and subordinate bus numbers of the bridge header and picks the outcome.

Both sources use the same routing rules, but an unroutable access ends differently for each. A window access that cannot be routed gets an error completion when it is a read, and its write is squashed. A register-pair access that cannot be routed reads back all ones, and its write is silently discarded. Window accesses must also fit within one aligned 4-byte word, or they end in an error completion. The unit holds one access at a time. All three ports use valid/ready handshakes.

Top module: `cfg_route_unit`

## Requirements
- R1: The link port carries the fields taken from the address: bus = addr[27:20], device = addr[19:15], function = addr[14:12], extended register = addr[11:8], register = addr[7:2]. It also carries the write flag, the byte enables and the write data of the accepted access.
- R2: A routable access whose bus equals the secondary bus number and whose device is 0 is sent as a Type 0 request (lnk_type1 = 0). The same bus with a nonzero device is unroutable.
- R3: An access whose bus differs from both the primary and secondary numbers and is at most the subordinate number is sent as a Type 1 request (lnk_type1 = 1). A bus one above the subordinate number is unroutable.
- R4: An unroutable window access (req_src = 0) causes no link request. A read gets a completion with cpl_err = 1 and zero data. A write is squashed without any completion, and req_ready is high again one cycle after acceptance.
- R5: An unroutable register-pair access (req_src = 1) causes no link request. A read gets a completion with cpl_err = 0 and all-ones data. A write is discarded without any completion.
- R6: A register-pair access is sent as Type 0 only if its bus also differs from the primary bus number. A window access has no such condition.
- R7: A window access is legal only when 1 <= req_len <= 4 and addr[1:0] + req_len <= 4. An illegal window access, read or write, gets an error completion and causes no link traffic. Register-pair accesses are not size-checked.
- R8: While lnk_valid is high and lnk_ready is low, lnk_valid and every link field hold their values.
- R9: While cpl_valid is high and cpl_ready is low, cpl_valid, cpl_err and cpl_rdata hold their values.
- R10: req_ready is low while a link request or completion is pending. At most one of lnk_valid and cpl_valid is high at a time.
- R11: The routing decision uses the bus numbers present in the acceptance cycle. Later changes do not alter a pending request.
- R12: After reset, req_ready is high and lnk_valid and cpl_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Unit can take an access |
| req_src | input | 1 | 0 = translation window, 1 = address/data register pair |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Translated configuration address |
| req_len | input | 3 | Access size in bytes |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| pri_bus | input | 8 | Primary bus number from bridge header |
| sec_bus | input | 8 | Secondary bus number from bridge header |
| sub_bus | input | 8 | Subordinate bus number from bridge header |
| lnk_valid | output | 1 | Link request pending |
| lnk_ready | input | 1 | Link side takes the request |
| lnk_type1 | output | 1 | 1 = Type 1 request, 0 = Type 0 |
| lnk_write | output | 1 | Request is a write |
| lnk_bus | output | 8 | Target bus |
| lnk_dev | output | 5 | Target device |
| lnk_fn | output | 3 | Target function |
| lnk_ereg | output | 4 | Extended register number |
| lnk_reg | output | 6 | Register number |
| lnk_be | output | 4 | Byte enables |
| lnk_wdata | output | 32 | Write data |
| cpl_valid | output | 1 | Local completion pending |
| cpl_ready | input | 1 | Requester takes the completion |
| cpl_err | output | 1 | Completion carries an error |
| cpl_rdata | output | 32 | Completion read data |

## Verification
Accesses are aimed at the secondary bus with device 0 and with a nonzero device, at a bus between secondary and subordinate, at the subordinate bus itself and at one above it, and at the primary bus. Together these separate the Type 0, Type 1 and unroutable outcomes at their exact boundaries. Each unroutable pattern is sent from both sources and as both read and write, so error completion, all-ones data, squashed writes and discarded writes can each be told apart. A case with the secondary bus equal to the primary bus shows the extra own-bus condition of the register-pair path. Window sizes and offsets at and just past the word edge test the legality check. Bus numbers are changed after acceptance, and the link and completion ports are stalled, to show that a pending result is held.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  // Address field layout of a configuration target
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int EREG_W    = 4;
  localparam int REG_W     = 6;
  localparam int REG_LSB   = 2;
  localparam int EREG_LSB  = REG_LSB + REG_W;
  localparam int FN_LSB    = EREG_LSB + EREG_W;
  localparam int DEV_LSB   = FN_LSB + FN_W;
  localparam int BUS_LSB   = DEV_LSB + DEV_W;
  localparam int CFG_ADDR_W = BUS_LSB + BUS_W;

  typedef struct packed {
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   fn;
    logic [EREG_W-1:0] ereg;
    logic [REG_W-1:0]  rnum;
  } cfg_tgt_t;

  typedef enum logic {
    SRC_WIN  = 1'b0,
    SRC_PAIR = 1'b1
  } cfg_src_e;

  typedef enum logic [2:0] {
    ACT_T0   = 3'd0,
    ACT_T1   = 3'd1,
    ACT_ERR  = 3'd2,
    ACT_ONES = 3'd3,
    ACT_DROP = 3'd4
  } route_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_CPL  = 2'd2
  } hold_st_e;

endpackage

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_route_pkg::*;
(
  input  logic [CFG_ADDR_W-1:0] addr_i,
  output cfg_tgt_t              tgt_o
);

  always_comb begin
    tgt_o.bus  = addr_i[BUS_LSB  +: BUS_W];
    tgt_o.dev  = addr_i[DEV_LSB  +: DEV_W];
    tgt_o.fn   = addr_i[FN_LSB   +: FN_W];
    tgt_o.ereg = addr_i[EREG_LSB +: EREG_W];
    tgt_o.rnum = addr_i[REG_LSB  +: REG_W];
  end

endmodule

// File: rtl/cfg_access_check.sv
module cfg_access_check #(
  parameter int LEN_W      = 3,
  parameter int WORD_BYTES = 4,
  localparam int LO_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int SUM_W     = ((LEN_W > LO_W) ? LEN_W : LO_W) + 2
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LO_W-1:0]  lo_i,
  output logic             legal_o
);

  logic [SUM_W-1:0] end_off;
  logic             size_ok;
  logic             span_ok;

  always_comb begin
    end_off = SUM_W'(lo_i) + SUM_W'(len_i);
    size_ok = (len_i != '0) && (SUM_W'(len_i) <= SUM_W'(WORD_BYTES));
    span_ok = end_off <= SUM_W'(WORD_BYTES);
    legal_o = size_ok && span_ok;
  end

endmodule

// File: rtl/cfg_route_decide.sv
module cfg_route_decide
  import cfg_route_pkg::*;
(
  input  cfg_tgt_t          tgt_i,
  input  cfg_src_e          src_i,
  input  logic              write_i,
  input  logic              legal_i,
  input  logic [BUS_W-1:0]  pri_i,
  input  logic [BUS_W-1:0]  sec_i,
  input  logic [BUS_W-1:0]  sub_i,
  output route_act_e        act_o
);

  logic on_sec;
  logic on_pri;
  logic dev_zero;
  logic hit_t0;
  logic hit_t1;

  always_comb begin
    on_sec   = (tgt_i.bus == sec_i);
    on_pri   = (tgt_i.bus == pri_i);
    dev_zero = (tgt_i.dev == '0);
    // register-pair path must also avoid the controller's own bus
    hit_t0   = on_sec && dev_zero && ((src_i == SRC_WIN) || !on_pri);
    hit_t1   = !on_pri && !on_sec && (tgt_i.bus <= sub_i);

    if ((src_i == SRC_WIN) && !legal_i) begin
      act_o = ACT_ERR;
    end else if (hit_t0) begin
      act_o = ACT_T0;
    end else if (hit_t1) begin
      act_o = ACT_T1;
    end else if (write_i) begin
      act_o = ACT_DROP;
    end else if (src_i == SRC_WIN) begin
      act_o = ACT_ERR;
    end else begin
      act_o = ACT_ONES;
    end
  end

endmodule

// File: rtl/cfg_req_hold.sv
module cfg_req_hold
  import cfg_route_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  route_act_e        act_i,
  input  cfg_tgt_t          tgt_i,
  input  logic              write_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lnk_ready_i,
  input  logic              cpl_ready_i,
  output logic              idle_o,
  output logic              lnk_valid_o,
  output logic              lnk_type1_o,
  output logic              lnk_write_o,
  output cfg_tgt_t          lnk_tgt_o,
  output logic [BE_W-1:0]   lnk_be_o,
  output logic [DATA_W-1:0] lnk_wdata_o,
  output logic              cpl_valid_o,
  output logic              cpl_err_o,
  output logic [DATA_W-1:0] cpl_rdata_o
);

  hold_st_e          st_q, st_d;
  route_act_e        act_q;
  cfg_tgt_t          tgt_q;
  logic              write_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;

  // next-state process
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_i) begin
          unique case (act_i)
            ACT_T0, ACT_T1:    st_d = ST_LINK;
            ACT_ERR, ACT_ONES: st_d = ST_CPL;
            default:           st_d = ST_IDLE;
          endcase
        end
      end
      ST_LINK: if (lnk_ready_i) st_d = ST_IDLE;
      ST_CPL:  if (cpl_ready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // payload registers, loaded only on acceptance
  always_ff @(posedge clk) begin
    if (accept_i) begin
      act_q   <= act_i;
      tgt_q   <= tgt_i;
      write_q <= write_i;
      be_q    <= be_i;
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    idle_o      = (st_q == ST_IDLE);
    lnk_valid_o = (st_q == ST_LINK);
    lnk_type1_o = (act_q == ACT_T1);
    lnk_write_o = write_q;
    lnk_tgt_o   = tgt_q;
    lnk_be_o    = be_q;
    lnk_wdata_o = wdata_q;
    cpl_valid_o = (st_q == ST_CPL);
    cpl_err_o   = (act_q == ACT_ERR);
    cpl_rdata_o = (act_q == ACT_ONES) ? '1 : '0;
  end

endmodule

// File: rtl/cfg_route_unit.sv
module cfg_route_unit
  import cfg_route_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3,
  localparam int BE_W  = DATA_W / 8,
  localparam int LO_W  = (BE_W > 1) ? $clog2(BE_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_src,
  input  logic                  req_write,
  input  logic [CFG_ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [BE_W-1:0]       req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [BUS_W-1:0]      pri_bus,
  input  logic [BUS_W-1:0]      sec_bus,
  input  logic [BUS_W-1:0]      sub_bus,
  output logic                  lnk_valid,
  input  logic                  lnk_ready,
  output logic                  lnk_type1,
  output logic                  lnk_write,
  output logic [BUS_W-1:0]      lnk_bus,
  output logic [DEV_W-1:0]      lnk_dev,
  output logic [FN_W-1:0]       lnk_fn,
  output logic [EREG_W-1:0]     lnk_ereg,
  output logic [REG_W-1:0]      lnk_reg,
  output logic [BE_W-1:0]       lnk_be,
  output logic [DATA_W-1:0]     lnk_wdata,
  output logic                  cpl_valid,
  input  logic                  cpl_ready,
  output logic                  cpl_err,
  output logic [DATA_W-1:0]     cpl_rdata
);

  cfg_tgt_t   req_tgt;
  cfg_tgt_t   held_tgt;
  logic       win_legal;
  route_act_e route_act;
  cfg_src_e   src_e;
  logic       accept;
  logic       idle;

  assign src_e     = cfg_src_e'(req_src);
  assign req_ready = idle;
  assign accept    = req_valid && idle;

  cfg_field_decode u_decode (
    .addr_i (req_addr),
    .tgt_o  (req_tgt)
  );

  cfg_access_check #(
    .LEN_W      (LEN_W),
    .WORD_BYTES (BE_W)
  ) u_check (
    .len_i   (req_len),
    .lo_i    (req_addr[LO_W-1:0]),
    .legal_o (win_legal)
  );

  cfg_route_decide u_decide (
    .tgt_i   (req_tgt),
    .src_i   (src_e),
    .write_i (req_write),
    .legal_i (win_legal),
    .pri_i   (pri_bus),
    .sec_i   (sec_bus),
    .sub_i   (sub_bus),
    .act_o   (route_act)
  );

  cfg_req_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .act_i       (route_act),
    .tgt_i       (req_tgt),
    .write_i     (req_write),
    .be_i        (req_be),
    .wdata_i     (req_wdata),
    .lnk_ready_i (lnk_ready),
    .cpl_ready_i (cpl_ready),
    .idle_o      (idle),
    .lnk_valid_o (lnk_valid),
    .lnk_type1_o (lnk_type1),
    .lnk_write_o (lnk_write),
    .lnk_tgt_o   (held_tgt),
    .lnk_be_o    (lnk_be),
    .lnk_wdata_o (lnk_wdata),
    .cpl_valid_o (cpl_valid),
    .cpl_err_o   (cpl_err),
    .cpl_rdata_o (cpl_rdata)
  );

  assign lnk_bus  = held_tgt.bus;
  assign lnk_dev  = held_tgt.dev;
  assign lnk_fn   = held_tgt.fn;
  assign lnk_ereg = held_tgt.ereg;
  assign lnk_reg  = held_tgt.rnum;

endmodule

// File: rtl/cfg_route_unit_chk.sv
module cfg_route_unit_chk
  import cfg_route_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              lnk_valid,
  input logic              lnk_ready,
  input logic              lnk_type1,
  input logic              lnk_write,
  input logic [BUS_W-1:0]  lnk_bus,
  input logic [DEV_W-1:0]  lnk_dev,
  input logic [FN_W-1:0]   lnk_fn,
  input logic [EREG_W-1:0] lnk_ereg,
  input logic [REG_W-1:0]  lnk_reg,
  input logic [BE_W-1:0]   lnk_be,
  input logic [DATA_W-1:0] lnk_wdata,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic              cpl_err,
  input logic [DATA_W-1:0] cpl_rdata
);

  // R8
  lnk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid && !lnk_ready |=> lnk_valid &&
      $stable({lnk_type1, lnk_write, lnk_bus, lnk_dev, lnk_fn, lnk_ereg,
               lnk_reg, lnk_be, lnk_wdata}));

  // R9
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable({cpl_err, cpl_rdata}));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_valid || cpl_valid) |-> !req_ready);

  // R10
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_valid && cpl_valid));

  // R2
  t0_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid && !lnk_type1 |-> lnk_dev == '0);

  // R5
  ones_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_err |-> cpl_rdata == '1);

  // R4
  err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_err |-> cpl_rdata == '0);

endmodule

bind cfg_route_unit cfg_route_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .lnk_valid (lnk_valid),
  .lnk_ready (lnk_ready),
  .lnk_type1 (lnk_type1),
  .lnk_write (lnk_write),
  .lnk_bus   (lnk_bus),
  .lnk_dev   (lnk_dev),
  .lnk_fn    (lnk_fn),
  .lnk_ereg  (lnk_ereg),
  .lnk_reg   (lnk_reg),
  .lnk_be    (lnk_be),
  .lnk_wdata (lnk_wdata),
  .cpl_valid (cpl_valid),
  .cpl_ready (cpl_ready),
  .cpl_err   (cpl_err),
  .cpl_rdata (cpl_rdata)
);

// File: tb/cfg_route_unit_test.sv
module cfg_route_unit_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_src;
  logic        req_write;
  logic [27:0] req_addr;
  logic [2:0]  req_len;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [7:0]  pri_bus, sec_bus, sub_bus;
  logic        lnk_valid, lnk_ready, lnk_type1, lnk_write;
  logic [7:0]  lnk_bus;
  logic [4:0]  lnk_dev;
  logic [2:0]  lnk_fn;
  logic [3:0]  lnk_ereg;
  logic [5:0]  lnk_reg;
  logic [3:0]  lnk_be;
  logic [31:0] lnk_wdata;
  logic        cpl_valid, cpl_ready, cpl_err;
  logic [31:0] cpl_rdata;

  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  cfg_route_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_be(req_be), .req_wdata(req_wdata),
    .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .lnk_valid(lnk_valid), .lnk_ready(lnk_ready), .lnk_type1(lnk_type1),
    .lnk_write(lnk_write), .lnk_bus(lnk_bus), .lnk_dev(lnk_dev),
    .lnk_fn(lnk_fn), .lnk_ereg(lnk_ereg), .lnk_reg(lnk_reg),
    .lnk_be(lnk_be), .lnk_wdata(lnk_wdata),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_err(cpl_err),
    .cpl_rdata(cpl_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Offer one access; returns at the negedge after the acceptance edge
  task automatic apply_req(input logic src, input logic [7:0] bus, input logic [4:0] dev,
                           input logic [2:0] fn, input logic [3:0] ereg, input logic [5:0] rn,
                           input logic [1:0] lo, input logic wr, input logic [2:0] len,
                           input logic [3:0] be, input logic [31:0] wd);
    check("R10 ready before offer", 32'(req_ready), 32'd1);
    req_src   = src;
    req_addr  = {bus, dev, fn, ereg, rn, lo};
    req_write = wr;
    req_len   = len;
    req_be    = be;
    req_wdata = wd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_link(input string tag, input logic t1, input logic [7:0] bus,
                             input logic [4:0] dev, input logic [2:0] fn, input logic [3:0] ereg,
                             input logic [5:0] rn, input logic wr, input logic [3:0] be,
                             input logic [31:0] wd, input int stall);
    for (int i = 0; i <= stall; i++) begin
      check({tag, " lnk_valid"}, 32'(lnk_valid), 32'd1);
      check({tag, " cpl_valid"}, 32'(cpl_valid), 32'd0);
      check({tag, " type1"}, 32'(lnk_type1), 32'(t1));
      check({tag, " fields"}, {lnk_bus, lnk_dev, lnk_fn, lnk_ereg, lnk_reg, 6'd0},
            {bus, dev, fn, ereg, rn, 6'd0});
      check({tag, " write"}, 32'(lnk_write), 32'(wr));
      check({tag, " be"}, 32'(lnk_be), 32'(be));
      if (wr) check({tag, " wdata"}, lnk_wdata, wd);
      if (i < stall) begin
        check({tag, " R10 busy"}, 32'(req_ready), 32'd0);
        @(negedge clk);
      end
    end
    lnk_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lnk_ready = 1'b0;
    check({tag, " link released"}, 32'(lnk_valid), 32'd0);
    check({tag, " R10 ready again"}, 32'(req_ready), 32'd1);
  endtask

  task automatic expect_cpl(input string tag, input logic err, input logic [31:0] rd,
                            input int stall);
    for (int i = 0; i <= stall; i++) begin
      check({tag, " cpl_valid"}, 32'(cpl_valid), 32'd1);
      check({tag, " no link"}, 32'(lnk_valid), 32'd0);
      check({tag, " err"}, 32'(cpl_err), 32'(err));
      check({tag, " rdata"}, cpl_rdata, rd);
      if (i < stall) begin
        check({tag, " R10 busy"}, 32'(req_ready), 32'd0);
        @(negedge clk);
      end
    end
    cpl_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpl_ready = 1'b0;
    check({tag, " cpl released"}, 32'(cpl_valid), 32'd0);
    check({tag, " R10 ready again"}, 32'(req_ready), 32'd1);
  endtask

  task automatic expect_drop(input string tag);
    check({tag, " no link"}, 32'(lnk_valid), 32'd0);
    check({tag, " no cpl"}, 32'(cpl_valid), 32'd0);
    check({tag, " ready"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    check({tag, " still quiet"}, 32'(lnk_valid | cpl_valid), 32'd0);
  endtask

  task automatic test_reset();
    check("R12 req_ready", 32'(req_ready), 32'd1);
    check("R12 lnk_valid", 32'(lnk_valid), 32'd0);
    check("R12 cpl_valid", 32'(cpl_valid), 32'd0);
  endtask

  task automatic test_type0();
    apply_req(1'b0, 8'h02, 5'd0, 3'd3, 4'hA, 6'h15, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_link("R1 R2 R8 window T0 read", 1'b0, 8'h02, 5'd0, 3'd3, 4'hA, 6'h15,
                1'b0, 4'hF, 32'h0, 3);
    apply_req(1'b1, 8'h02, 5'd0, 3'd7, 4'h1, 6'h3F, 2'd0, 1'b1, 3'd4, 4'h5, 32'hCAFE_F00D);
    expect_link("R1 R2 pair T0 write", 1'b0, 8'h02, 5'd0, 3'd7, 4'h1, 6'h3F,
                1'b1, 4'h5, 32'hCAFE_F00D, 0);
    apply_req(1'b0, 8'h02, 5'd3, 3'd0, 4'h0, 6'h01, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_cpl("R2 nonzero device on secondary", 1'b1, 32'h0, 0);
  endtask

  task automatic test_type1();
    apply_req(1'b0, 8'h05, 5'd17, 3'd2, 4'h3, 6'h08, 2'd0, 1'b1, 3'd4, 4'hC, 32'h1234_5678);
    expect_link("R1 R3 T1 at subordinate", 1'b1, 8'h05, 5'd17, 3'd2, 4'h3, 6'h08,
                1'b1, 4'hC, 32'h1234_5678, 1);
    apply_req(1'b1, 8'h03, 5'd0, 3'd0, 4'h0, 6'h00, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_link("R3 T1 inside range", 1'b1, 8'h03, 5'd0, 3'd0, 4'h0, 6'h00,
                1'b0, 4'hF, 32'h0, 0);
    apply_req(1'b0, 8'h06, 5'd0, 3'd0, 4'h0, 6'h00, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_cpl("R3 R4 subordinate plus one", 1'b1, 32'h0, 0);
  endtask

  task automatic test_win_unrouted();
    apply_req(1'b0, 8'h01, 5'd0, 3'd0, 4'h0, 6'h02, 2'd0, 1'b1, 3'd4, 4'hF, 32'hDEAD_BEEF);
    expect_drop("R4 window write to primary");
    apply_req(1'b0, 8'h01, 5'd0, 3'd0, 4'h0, 6'h02, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_cpl("R4 window read to primary", 1'b1, 32'h0, 2);
  endtask

  task automatic test_pair_unrouted();
    apply_req(1'b1, 8'h06, 5'd0, 3'd0, 4'h0, 6'h04, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_cpl("R5 R9 pair read unrouted", 1'b0, 32'hFFFF_FFFF, 3);
    apply_req(1'b1, 8'h06, 5'd0, 3'd0, 4'h0, 6'h04, 2'd0, 1'b1, 3'd4, 4'hF, 32'h5555_AAAA);
    expect_drop("R5 pair write unrouted");
  endtask

  task automatic test_own_bus();
    sec_bus = 8'h01;
    apply_req(1'b1, 8'h01, 5'd0, 3'd0, 4'h0, 6'h00, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_cpl("R6 pair own bus not T0", 1'b0, 32'hFFFF_FFFF, 0);
    apply_req(1'b0, 8'h01, 5'd0, 3'd1, 4'h0, 6'h00, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_link("R6 window own bus T0", 1'b0, 8'h01, 5'd0, 3'd1, 4'h0, 6'h00,
                1'b0, 4'hF, 32'h0, 0);
    sec_bus = 8'h02;
  endtask

  task automatic test_win_size();
    apply_req(1'b0, 8'h02, 5'd0, 3'd0, 4'h0, 6'h00, 2'd3, 1'b0, 3'd2, 4'h8, 32'h0);
    expect_cpl("R7 crossing read", 1'b1, 32'h0, 0);
    apply_req(1'b0, 8'h02, 5'd0, 3'd0, 4'h0, 6'h00, 2'd0, 1'b1, 3'd5, 4'hF, 32'h1);
    expect_cpl("R7 oversize write", 1'b1, 32'h0, 0);
    apply_req(1'b0, 8'h02, 5'd0, 3'd0, 4'h0, 6'h00, 2'd0, 1'b0, 3'd0, 4'h0, 32'h0);
    expect_cpl("R7 zero length", 1'b1, 32'h0, 0);
    apply_req(1'b0, 8'h02, 5'd0, 3'd0, 4'h0, 6'h09, 2'd3, 1'b0, 3'd1, 4'h8, 32'h0);
    expect_link("R7 last byte legal", 1'b0, 8'h02, 5'd0, 3'd0, 4'h0, 6'h09,
                1'b0, 4'h8, 32'h0, 0);
    apply_req(1'b1, 8'h02, 5'd0, 3'd0, 4'h0, 6'h0A, 2'd3, 1'b0, 3'd7, 4'hF, 32'h0);
    expect_link("R7 pair not size checked", 1'b0, 8'h02, 5'd0, 3'd0, 4'h0, 6'h0A,
                1'b0, 4'hF, 32'h0, 0);
  endtask

  task automatic test_bus_sample();
    apply_req(1'b0, 8'h04, 5'd2, 3'd0, 4'h0, 6'h11, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    sub_bus = 8'h03;
    pri_bus = 8'h04;
    expect_link("R11 change after accept", 1'b1, 8'h04, 5'd2, 3'd0, 4'h0, 6'h11,
                1'b0, 4'hF, 32'h0, 2);
    apply_req(1'b0, 8'h04, 5'd2, 3'd0, 4'h0, 6'h11, 2'd0, 1'b0, 3'd4, 4'hF, 32'h0);
    expect_cpl("R11 new numbers used", 1'b1, 32'h0, 0);
    pri_bus = 8'h01;
    sub_bus = 8'h05;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_src = 1'b0; req_write = 1'b0; req_addr = '0;
    req_len = 3'd4; req_be = '0; req_wdata = '0;
    pri_bus = 8'h01; sec_bus = 8'h02; sub_bus = 8'h05;
    lnk_ready = 1'b0; cpl_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_type0();
    test_type1();
    test_win_unrouted();
    test_pair_unrouted();
    test_own_bus();
    test_win_size();
    test_bus_sample();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule